// File: doc/BRIEF.md
# Doubleword Atomic Memory Operation Unit

This unit executes the doubleword atomic instructions of a RISC-V style core. When it is idle, a one-cycle `start` pulse captures a 32-bit instruction word and the two source register values. The unit decodes the instruction and runs it against a simple synchronous memory port. It then reports, for one cycle, the destination register index, the value to write back and a write-enable. Read-modify-write atomics make one read access. In the next cycle they make one write to the same address. The write carries the old memory value combined with the second operand.

The unit holds one reservation, made of a valid flag and an address. Load-reserved sets it. Store-conditional consumes it and uses it to decide whether its store takes place. An encoding that the unit does not recognise raises an illegal flag instead of touching memory. The acquire and release bits are passed out unchanged for the core's ordering logic.

Top module: `amo_unit`

## Requirements
- R1: An instruction is legal only when bits [6:0] are 0101111, bits [14:12] are 011 and bits [31:27] hold one of the eleven operation codes. Any other word gives `illegal`=1 together with `done`, no memory request and `wb_en`=0.
- R2: Every memory request uses the full value of `src1` as its address, with no offset added.
- R3: A read-modify-write atomic issues a read and, in the next cycle, a write to the same address. It returns the old memory value on `wb_data`. The operation codes are 00001 swap, 00000 add, 00100 xor, 01100 and and 01000 or.
- R4: The combined values are: swap stores `src2` unchanged, add stores old+`src2` modulo 2^64, and xor, and and or store the bitwise result.
- R5: Code 10000 (min) and code 10100 (max) compare old and `src2` as two's complement numbers and store the smaller or the larger one.
- R6: Code 11000 (unsigned min) and code 11100 (unsigned max) compare old and `src2` as unsigned numbers and store the smaller or the larger one.
- R7: When rd (bits [11:7]) is zero, `wb_en` stays 0, but the memory update still takes place.
- R8: Load-reserved (code 00010) returns the memory value and records a valid reservation on its address. If its rs2 field (bits [24:20]) is not zero, the instruction is illegal.
- R9: Store-conditional (code 00011) writes `src2` to memory and returns 0 only when the reservation is valid and its address equals `src1`.
- R10: A store-conditional that fails makes no memory request and returns 1. Every store-conditional clears the reservation, and so does reset.
- R11: `acq` and `rel` reflect bits [26] and [25] of the captured instruction.
- R12: `done` rises 3 cycles after the `start` edge for load-reserved and read-modify-write atomics, and 2 cycles after it for store-conditional and illegal words. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture instruction and operands when idle |
| instr | input | 32 | Instruction word |
| src1 | input | 64 | Value of register rs1 (address) |
| src2 | input | 64 | Value of register rs2 (operand) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unrecognised encoding, valid with done |
| acq | output | 1 | Acquire bit of the captured instruction |
| rel | output | 1 | Release bit of the captured instruction |
| wb_en | output | 1 | Register write-back enable, valid with done |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Write-back value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when set, read otherwise |
| mem_addr | output | 64 | Memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
The combine operations are driven with random operands, with sign-boundary values mixed in. Some pairs put a negative number against a positive one, so the results separate signed from unsigned comparison, and additions that overflow show that the sum wraps. Reservation sequences test store-conditional in four ways: after reset, after a matching load-reserved, a second time after the reservation has been used, and against a different address. Together these separate a hit from a miss. Malformed words cover a wrong width, a wrong major opcode, an unused operation code and a load-reserved with a nonzero rs2. A hold pattern keeps `start` high with different words during an operation, to show that the captured instruction is not disturbed.

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src1,
  input  logic [XLEN-1:0] src2,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            acq,
  output logic            rel,
  output logic            wb_en,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam logic [6:0] MAJOR = 7'b0101111;
  localparam logic [2:0] WIDTH = 3'b011;

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_LOAD, S_FIN} st_t;
  st_t st;

  logic [31:0]     ir;
  logic [XLEN-1:0] a_q, b_q, res_q, rsv_a, comb;
  logic            ill_q, rsv_v;

  wire [4:0] fn     = ir[31:27];
  wire       fmt_ok = (ir[6:0] == MAJOR) && (ir[14:12] == WIDTH);
  wire       is_lr  = (fn == 5'b00010);
  wire       is_sc  = (fn == 5'b00011);
  wire       is_rmw = fn inside {5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                                 5'b10000, 5'b10100, 5'b11000, 5'b11100};
  wire       legal  = fmt_ok && (is_rmw || is_sc || (is_lr && ir[24:20] == 5'd0));
  wire       sc_hit = rsv_v && (rsv_a == a_q);

  wire lt_s = $signed(mem_rdata) < $signed(b_q);
  wire lt_u = mem_rdata < b_q;

  always_comb begin
    case (fn)
      5'b00001: comb = b_q;
      5'b00000: comb = mem_rdata + b_q;
      5'b00100: comb = mem_rdata ^ b_q;
      5'b01100: comb = mem_rdata & b_q;
      5'b01000: comb = mem_rdata | b_q;
      5'b10000: comb = lt_s ? mem_rdata : b_q;
      5'b10100: comb = lt_s ? b_q : mem_rdata;
      5'b11000: comb = lt_u ? mem_rdata : b_q;
      5'b11100: comb = lt_u ? b_q : mem_rdata;
      default:  comb = b_q;
    endcase
  end

  assign mem_req   = (st == S_EXEC && legal && (!is_sc || sc_hit)) || (st == S_LOAD && !is_lr);
  assign mem_we    = mem_req && (st == S_LOAD || is_sc);
  assign mem_addr  = a_q;
  assign mem_wdata = (st == S_LOAD) ? comb : b_q;

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign illegal = done && ill_q;
  assign wb_en   = done && !ill_q && (ir[11:7] != 5'd0);
  assign wb_rd   = ir[11:7];
  assign wb_data = res_q;
  assign acq     = ir[26];
  assign rel     = ir[25];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ir    <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      ill_q <= 1'b0;
      rsv_v <= 1'b0;
      rsv_a <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ir  <= instr;
          a_q <= src1;
          b_q <= src2;
          st  <= S_EXEC;
        end
        S_EXEC: begin
          ill_q <= !legal;
          if (!legal) st <= S_FIN;
          else if (is_sc) begin
            res_q <= sc_hit ? '0 : XLEN'(1);
            rsv_v <= 1'b0;
            st    <= S_FIN;
          end else st <= S_LOAD;
        end
        S_LOAD: begin
          res_q <= mem_rdata;
          if (is_lr) begin
            rsv_v <= 1'b1;
            rsv_a <= a_q;
          end
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_illegal_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(!mem_req));
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr));
  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !is_sc) |-> $past(mem_req && !mem_we));
  a_r7_no_wb_to_x0: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_rd != 5'd0));
  a_r10_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ill_q && is_sc) |-> !rsv_v);
  a_r8_rsv_set_by_lr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsv_v) |-> $past(st == S_LOAD && is_lr));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/amo_unit_test.sv
module amo_unit_test;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [31:0] instr = '0;
  logic [63:0] src1 = '0, src2 = '0, mem_rdata;
  logic        busy, done, illegal, acq, rel, wb_en, mem_req, mem_we;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data, mem_addr, mem_wdata;

  always #4 clk = ~clk;

  amo_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .src1(src1), .src2(src2),
    .busy(busy), .done(done), .illegal(illegal), .acq(acq), .rel(rel), .wb_en(wb_en), .wb_rd(wb_rd),
    .wb_data(wb_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [63:0] mem_m [16];
  logic [63:0] ref_mem [16];
  logic [63:0] cur_addr = '0;
  int req_cnt = 0, addr_err = 0;
  int errors = 0, checks = 0;
  bit ref_rv = 0;
  logic [63:0] ref_ra = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) mem_m[k] <= ref_mem[k];
    end else if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (mem_addr !== cur_addr) addr_err <= addr_err + 1;
      if (mem_we) mem_m[mem_addr[6:3]] <= mem_wdata;
      else mem_rdata <= mem_m[mem_addr[6:3]];
    end
  end

  initial begin
    #1_600_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic [31:0] mk(input [4:0] fn, input bit aq, input bit rl, input [4:0] r2, input [4:0] rd);
    return {fn, aq, rl, r2, 5'd10, 3'b011, rd, 7'b0101111};
  endfunction

  function automatic bit legal_f(input [31:0] w);
    logic [4:0] f = w[31:27];
    if (w[6:0] != 7'b0101111 || w[14:12] != 3'b011) return 0;
    if (f == 5'b00010) return w[24:20] == 0;
    return f inside {5'b00011, 5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                     5'b10000, 5'b10100, 5'b11000, 5'b11100};
  endfunction

  function automatic [63:0] comb_f(input [4:0] f, input [63:0] o, input [63:0] b);
    case (f)
      5'b00001: return b;
      5'b00000: return o + b;
      5'b00100: return o ^ b;
      5'b01100: return o & b;
      5'b01000: return o | b;
      5'b10000: return ($signed(o) < $signed(b)) ? o : b;
      5'b10100: return ($signed(o) < $signed(b)) ? b : o;
      5'b11000: return (o < b) ? o : b;
      default:  return (o < b) ? b : o;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input [63:0] act, input [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic [63:0] slot(input int k);
    return 64'h1000 + 64'(k) * 8;
  endfunction

  task automatic run(input [31:0] w, input [63:0] a, input [63:0] b, input bit hold, input string tag);
    logic [4:0] f = w[31:27];
    bit lg = legal_f(w);
    logic [63:0] old = ref_mem[a[6:3]];
    logic [63:0] ed = '0;
    int lat, reqs, r0, ae0, cyc;
    bit mem_ok = 1;
    if (!lg) begin lat = 2; reqs = 0; end
    else if (f == 5'b00011) begin
      bit hit = ref_rv && ref_ra == a;
      ed = hit ? 64'd0 : 64'd1;
      if (hit) ref_mem[a[6:3]] = b;
      ref_rv = 0; lat = 2; reqs = hit ? 1 : 0;
    end else if (f == 5'b00010) begin
      ed = old; ref_rv = 1; ref_ra = a; lat = 3; reqs = 1;
    end else begin
      ed = old; ref_mem[a[6:3]] = comb_f(f, old, b); lat = 3; reqs = 2;
    end
    r0 = req_cnt; ae0 = addr_err; cur_addr = a;
    instr = w; src1 = a; src2 = b; start = 1;
    @(negedge clk);
    if (hold) begin instr = ~w; src1 = ~a; src2 = ~b; end else start = 0;
    cyc = 1;
    while (!done && cyc < 10) begin @(negedge clk); cyc++; end
    start = 0;
    chk(cyc == lat, {tag, " R12 latency"}, 64'(cyc), 64'(lat));
    chk(illegal == !lg, {tag, " R1 illegal"}, 64'(illegal), 64'(!lg));
    chk(wb_en == (lg && w[11:7] != 0), {tag, " R7 wb_en"}, 64'(wb_en), 64'(lg && w[11:7] != 0));
    if (lg && w[11:7] != 0) begin
      chk(wb_data == ed, {tag, " R3 wb_data"}, wb_data, ed);
      chk(wb_rd == w[11:7], {tag, " R3 wb_rd"}, 64'(wb_rd), 64'(w[11:7]));
    end
    chk(acq == w[26] && rel == w[25], {tag, " R11 acq/rel"}, {acq, rel}, {w[26], w[25]});
    @(negedge clk);
    chk(req_cnt - r0 == reqs, {tag, " R10 request count"}, 64'(req_cnt - r0), 64'(reqs));
    chk(addr_err == ae0, {tag, " R2 address"}, 64'(addr_err - ae0), 64'd0);
    for (int k = 0; k < 16; k++) if (mem_m[k] !== ref_mem[k]) mem_ok = 0;
    chk(mem_ok, {tag, " R4 memory image"}, mem_m[a[6:3]], ref_mem[a[6:3]]);
  endtask

  localparam logic [4:0] FNS [11] = '{5'b00010, 5'b00011, 5'b00001, 5'b00000, 5'b00100,
    5'b01100, 5'b01000, 5'b10000, 5'b10100, 5'b11000, 5'b11100};

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 16; k++) ref_mem[k] = {$urandom, $urandom};
    ref_mem[1] = 64'hFFFF_FFFF_FFFF_FFF0;
    ref_mem[2] = 64'h7FFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !wb_en && !mem_req, "reset R12 idle", {busy, done, wb_en, mem_req}, 0);

    run(mk(5'b00011, 0, 0, 5'd3, 5'd4), slot(3), 64'h55, 0, "sc after reset R10");
    run(mk(5'b00010, 1, 0, 5'd0, 5'd5), slot(3), 0, 0, "lr R8");
    run(mk(5'b00011, 0, 1, 5'd3, 5'd6), slot(3), 64'hABCD, 0, "sc hit R9");
    run(mk(5'b00011, 0, 0, 5'd3, 5'd6), slot(3), 64'h1111, 0, "sc reused R10");
    run(mk(5'b00010, 0, 0, 5'd0, 5'd5), slot(2), 0, 0, "lr slot2 R8");
    run(mk(5'b00011, 0, 0, 5'd3, 5'd6), slot(3), 64'h2222, 0, "sc other addr R10");
    run(mk(5'b10000, 0, 0, 5'd1, 5'd7), slot(1), 64'd5, 0, "min neg R5");
    run(mk(5'b11000, 0, 0, 5'd1, 5'd7), slot(4), 64'hFFFF_FFFF_0000_0000, 0, "minu R6");
    run(mk(5'b10100, 1, 1, 5'd1, 5'd8), slot(4), 64'h8000_0000_0000_0000, 0, "max R5");
    run(mk(5'b11100, 0, 0, 5'd1, 5'd8), slot(5), 64'h8000_0000_0000_0000, 0, "maxu R6");
    run(mk(5'b00000, 0, 0, 5'd1, 5'd9), slot(2), 64'd1, 0, "add wrap R4");
    run(mk(5'b00001, 0, 0, 5'd1, 5'd0), slot(6), 64'hDEAD_BEEF, 0, "swap rd0 R7");
    run(mk(5'b00100, 0, 0, 5'd1, 5'd0), slot(7), 64'hF0F0, 0, "xor rd0 R7");
    run(mk(5'b00010, 0, 0, 5'd4, 5'd5), slot(3), 0, 0, "lr rs2 R8");
    run(mk(5'b00101, 0, 0, 5'd1, 5'd5), slot(3), 0, 0, "bad fn R1");
    run(mk(5'b00000, 0, 0, 5'd1, 5'd5) & ~32'h0000_1000, slot(3), 7, 0, "bad width R1");
    run(mk(5'b00000, 0, 0, 5'd1, 5'd5) ^ 32'h1, slot(3), 7, 0, "bad major R1");
    run(mk(5'b01000, 0, 0, 5'd1, 5'd11), slot(8), 64'h3, 1, "or hold R12");

    for (int i = 0; i < 300; i++) begin
      logic [4:0] f = FNS[$urandom_range(10)];
      logic [31:0] w = mk(f, 1'($urandom), 1'($urandom), (f == 5'b00010) ? 5'd0 : 5'($urandom),
                          5'($urandom));
      logic [63:0] b = {$urandom, $urandom};
      if ($urandom_range(9) == 0) b = 64'h8000_0000_0000_0000;
      if ($urandom_range(9) == 0) w[14:12] = 3'($urandom);
      run(w, slot($urandom_range(15)), b, 1'($urandom_range(7) == 0), "random R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule